// File: doc/BRIEF.md
# Slot-Drained Video Write Queue

This block buffers host writes to the video memories in a four-entry ring and releases them only during external access slots granted by a slot scheduler outside the block. Each accepted write is stamped with the current access address, the current command code, the data word and a due time. The due time is the current master-clock count plus a fixed number of slot lengths. A slot lasts 16 clocks in wide mode and 20 clocks in narrow mode. The queue head is serviced in a slot only once its due time has been reached. A word written to byte-wide video RAM is drained as two byte writes in two separate slots.

Host writes enter on a valid/ready stream. `wr_ready` is low while all four entries are occupied. A write held with `wr_valid` high waits until a slot frees an entry, and no data is lost or reordered. Command loads, read requests and slot strobes are plain single-cycle pulses. The block drives a 16-bit status word with empty and full flags. It also returns host reads of colour RAM and scroll RAM in which the bits those memories do not store are filled from the stale data word held in the ring entry at the write index.

Top module: `vid_wr_fifo`

## Requirements
- R1: After reset the status word is 0x3600, `wr_ready` is high, `acc_addr` is 0, and every ring payload is zero, so a colour-RAM read with raw data 0xFFFF returns 0x0EEE.
- R2: The status word is 0x3400 with bit 9 set when the ring is empty and bit 8 set when it holds four entries. `wr_ready` is low exactly when the ring is full.
- R3: `cmd_load` sets the access address and the command code. Each accepted write and each `rd_req` advances `acc_addr` by `autoinc`, and the entry keeps the address that was current when it was accepted.
- R4: An entry becomes due LAT slot lengths after acceptance, with a slot length of 16 clocks when `mode_wide` is 1 and 20 clocks when it is 0. A slot that sees no due head raises `slot_unused` and writes nothing.
- R5: An entry with code 3 (colour RAM, `mem_tgt`=1) or code 5 (scroll RAM, `mem_tgt`=2) writes its full word in one slot and leaves the ring.
- R6: An entry with code 1 (video RAM, `mem_tgt`=0, `mem_byte`=1) writes its high byte to its address in one slot and stays queued. In the next serviced slot it writes its low byte to the address XOR 1 and leaves the ring.
- R7: After an `rd_req`, the next slot is taken by the read: it raises `slot_unused` and leaves the queue untouched.
- R8: An entry with any other code leaves the ring in a serviced slot without a memory write and without `slot_unused`.
- R9: A read with code 8 returns (raw AND 0x0EEE) OR (stale word AND 0xF111) one cycle after `rd_req`, where the stale word is the data of the ring entry at the write index.
- R10: A read with code 4 returns (raw AND 0x03FF) OR (stale word AND 0xF800), with bit 10 zero. A read with any other code returns the raw word.
- R11: A write accepted in the same cycle as a slot that removes the last entry leaves exactly that new entry queued.
- R12: Entries drain in the order they were accepted, including a write that was held back while the ring was full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wide | input | 1 | 1: 16-clock slots, 0: 20-clock slots |
| cmd_load | input | 1 | Load access address and command code |
| cmd_code | input | 4 | Command code to load |
| cmd_addr | input | 16 | Access address to load |
| autoinc | input | 8 | Address step after each access |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Ring has room for a write |
| wr_data | input | 16 | Host write word |
| slot_strobe | input | 1 | External access slot in this cycle |
| rd_req | input | 1 | Host read of the current target |
| rd_raw | input | 16 | Raw memory word at `acc_addr` |
| rd_valid | output | 1 | Merged read word valid |
| rd_data | output | 16 | Merged read word |
| acc_addr | output | 16 | Current access address |
| mem_we | output | 1 | Memory write strobe |
| mem_tgt | output | 2 | 0 video RAM, 1 colour RAM, 2 scroll RAM |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Write word, or byte in bits 7:0 |
| mem_byte | output | 1 | Byte-wide write |
| slot_unused | output | 1 | The last slot did no queue work |
| status | output | 16 | Status word with empty and full flags |

## Verification
Acceptance of a host write and removal of the last queued entry can fall on the same clock edge. The ring then has to take the new entry as the only one left, rather than marking itself empty. The bench provokes this by raising `wr_valid` and `slot_strobe` in one cycle while a single due entry is queued. It then checks that the old entry is written, that the status word stays 0x3400, and that the new word is written by a later slot. A second overlap is a host write held while the ring is full, against the slot that frees an entry. Here the bench checks that the held word is accepted on the following edge and drains last.

// File: rtl/vwq_pkg.sv
package vwq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CD_W   = 4;
  localparam int TIME_W = 16;

  typedef struct packed {
    logic [TIME_W-1:0] due;
    logic [ADDR_W-1:0] addr;
    logic [CD_W-1:0]   cd;
    logic [DATA_W-1:0] data;
    logic              partial;
  } vwq_entry_t;

  localparam logic [CD_W-1:0] CD_VRAM_WR  = 4'h1;
  localparam logic [CD_W-1:0] CD_CRAM_WR  = 4'h3;
  localparam logic [CD_W-1:0] CD_VSRAM_WR = 4'h5;
  localparam logic [CD_W-1:0] CD_CRAM_RD  = 4'h8;
  localparam logic [CD_W-1:0] CD_VSRAM_RD = 4'h4;

  typedef enum logic [1:0] {
    TGT_VRAM  = 2'd0,
    TGT_CRAM  = 2'd1,
    TGT_VSRAM = 2'd2
  } vwq_tgt_e;

  localparam logic [DATA_W-1:0] CRAM_KEEP   = 16'h0EEE;
  localparam logic [DATA_W-1:0] VSRAM_KEEP  = 16'h03FF;
  localparam logic [DATA_W-1:0] VSRAM_STALE = 16'hF800;
  localparam logic [DATA_W-1:0] STATUS_BASE = 16'h3400;
endpackage

// File: rtl/vwq_ring.sv
module vwq_ring
  import vwq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  vwq_entry_t        push_ent,
  input  logic              pop,
  input  logic              set_partial,
  output vwq_entry_t        head,
  output logic              head_vld,
  output logic [DATA_W-1:0] stale_data,
  output logic              empty,
  output logic              full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  vwq_entry_t     store [DEPTH];
  logic [IW-1:0]  wr_idx, rd_idx;
  logic           rd_vld;
  logic [IW-1:0]  wr_nxt, rd_nxt, rd_inc;
  logic           vld_nxt;

  always_comb begin
    rd_inc  = rd_idx + IW'(1);
    wr_nxt  = push ? wr_idx + IW'(1) : wr_idx;
    rd_nxt  = rd_idx;
    vld_nxt = rd_vld;
    if (!rd_vld) begin
      if (push) begin
        vld_nxt = 1'b1;
        rd_nxt  = wr_idx;
      end
    end else if (pop) begin
      rd_nxt = rd_inc;
      if (rd_inc == wr_nxt) vld_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      rd_vld <= 1'b0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (push) store[wr_idx] <= push_ent;
      if (set_partial) store[rd_idx].partial <= 1'b1;
      wr_idx <= wr_nxt;
      rd_idx <= rd_nxt;
      rd_vld <= vld_nxt;
    end
  end

  assign head       = store[rd_idx];
  assign head_vld   = rd_vld;
  assign stale_data = store[wr_idx].data;
  assign empty      = !rd_vld;
  assign full       = rd_vld && (rd_idx == wr_idx);
endmodule

// File: rtl/vwq_drain.sv
module vwq_drain
  import vwq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot,
  input  logic              rd_pend,
  input  logic              head_vld,
  input  vwq_entry_t        head,
  input  logic [TIME_W-1:0] now,
  output logic              pop,
  output logic              set_partial,
  output logic              mem_we,
  output logic [1:0]        mem_tgt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_byte,
  output logic              slot_unused
);
  logic [TIME_W-1:0] age;
  logic              due_ok, serve;
  logic              we_n, byte_n;
  vwq_tgt_e          tgt_n;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] data_n;

  always_comb begin
    age    = now - head.due;
    due_ok = !age[TIME_W-1];
    serve  = slot && !rd_pend && head_vld && due_ok;
    pop         = 1'b0;
    set_partial = 1'b0;
    we_n   = 1'b0;
    byte_n = 1'b0;
    tgt_n  = TGT_VRAM;
    addr_n = head.addr;
    data_n = head.data;
    if (serve) begin
      unique case (head.cd)
        CD_VRAM_WR: begin
          we_n   = 1'b1;
          byte_n = 1'b1;
          if (!head.partial) begin
            set_partial = 1'b1;
            data_n      = {8'h00, head.data[15:8]};
          end else begin
            pop    = 1'b1;
            addr_n = head.addr ^ ADDR_W'(1);
            data_n = {8'h00, head.data[7:0]};
          end
        end
        CD_CRAM_WR: begin
          we_n  = 1'b1;
          tgt_n = TGT_CRAM;
          pop   = 1'b1;
        end
        CD_VSRAM_WR: begin
          we_n  = 1'b1;
          tgt_n = TGT_VSRAM;
          pop   = 1'b1;
        end
        default: pop = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we      <= 1'b0;
      mem_tgt     <= 2'd0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      mem_byte    <= 1'b0;
      slot_unused <= 1'b0;
    end else begin
      mem_we      <= we_n;
      slot_unused <= slot && !serve;
      if (we_n) begin
        mem_tgt   <= tgt_n;
        mem_addr  <= addr_n;
        mem_wdata <= data_n;
        mem_byte  <= byte_n;
      end
    end
  end
endmodule

// File: rtl/vwq_rdmerge.sv
module vwq_rdmerge
  import vwq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [CD_W-1:0]   cd,
  input  logic [DATA_W-1:0] raw,
  input  logic [DATA_W-1:0] stale,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] merged;

  always_comb begin
    unique case (cd)
      CD_CRAM_RD:  merged = (raw & CRAM_KEEP) | (stale & ~CRAM_KEEP);
      CD_VSRAM_RD: merged = (raw & VSRAM_KEEP) | (stale & VSRAM_STALE);
      default:     merged = raw;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= merged;
    end
  end
endmodule

// File: rtl/vid_wr_fifo.sv
module vid_wr_fifo
  import vwq_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int LAT         = 3,
  parameter int SLOT_WIDE   = 16,
  parameter int SLOT_NARROW = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_wide,
  input  logic        cmd_load,
  input  logic [3:0]  cmd_code,
  input  logic [15:0] cmd_addr,
  input  logic [7:0]  autoinc,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [15:0] wr_data,
  input  logic        slot_strobe,
  input  logic        rd_req,
  input  logic [15:0] rd_raw,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic [15:0] acc_addr,
  output logic        mem_we,
  output logic [1:0]  mem_tgt,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic        mem_byte,
  output logic        slot_unused,
  output logic [15:0] status
);
  localparam logic [TIME_W-1:0] WAIT_WIDE   = TIME_W'(SLOT_WIDE * LAT);
  localparam logic [TIME_W-1:0] WAIT_NARROW = TIME_W'(SLOT_NARROW * LAT);

  logic [TIME_W-1:0] now;
  logic [CD_W-1:0]   code_q;
  logic              rd_pend;
  logic              push, pop, set_partial;
  logic              empty, full, head_vld;
  vwq_entry_t        head, push_ent;
  logic [DATA_W-1:0] stale;

  assign wr_ready = !full;
  assign push     = wr_valid && wr_ready;

  always_comb begin
    push_ent.due     = now + (mode_wide ? WAIT_WIDE : WAIT_NARROW);
    push_ent.addr    = acc_addr;
    push_ent.cd      = code_q;
    push_ent.data    = wr_data;
    push_ent.partial = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now      <= '0;
      acc_addr <= '0;
      code_q   <= '0;
      rd_pend  <= 1'b0;
    end else begin
      now <= now + TIME_W'(1);
      if (cmd_load) begin
        acc_addr <= cmd_addr;
        code_q   <= cmd_code;
      end else if (push || rd_req) begin
        acc_addr <= acc_addr + {8'h00, autoinc};
      end
      if (slot_strobe) rd_pend <= 1'b0;
      if (rd_req)      rd_pend <= 1'b1;
    end
  end

  vwq_ring #(.DEPTH(DEPTH)) ring_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_ent(push_ent),
    .pop(pop), .set_partial(set_partial), .head(head), .head_vld(head_vld),
    .stale_data(stale), .empty(empty), .full(full)
  );

  vwq_drain drain_i (
    .clk(clk), .rst_n(rst_n), .slot(slot_strobe), .rd_pend(rd_pend),
    .head_vld(head_vld), .head(head), .now(now), .pop(pop),
    .set_partial(set_partial), .mem_we(mem_we), .mem_tgt(mem_tgt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_byte(mem_byte),
    .slot_unused(slot_unused)
  );

  vwq_rdmerge merge_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .cd(code_q), .raw(rd_raw),
    .stale(stale), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign status = STATUS_BASE | {6'b0, empty, full, 8'b0};
endmodule

// File: rtl/vid_wr_fifo_chk.sv
module vid_wr_fifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        slot_strobe,
  input logic        rd_req,
  input logic        rd_valid,
  input logic        mem_we,
  input logic        slot_unused,
  input logic [15:0] status
);
  assert_status_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status[15:10] == 6'b001101) && (status[7:0] == 8'h00));

  assert_empty_full_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[9] && status[8]));

  assert_full_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[8] |-> !wr_ready);

  assert_push_fills_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !status[9]);

  assert_write_in_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(slot_strobe));

  assert_unused_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && slot_unused));

  assert_unused_from_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_unused |-> $past(slot_strobe));

  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req));
endmodule

bind vid_wr_fifo vid_wr_fifo_chk chk_i (.*);

// File: tb/vid_wr_fifo_tb_top.sv
`timescale 1ns/1ps
module vid_wr_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_wide, cmd_load, wr_valid, slot_strobe, rd_req;
  logic [3:0]  cmd_code;
  logic [15:0] cmd_addr, wr_data, rd_raw;
  logic [7:0]  autoinc;
  logic        wr_ready, rd_valid, mem_we, mem_byte, slot_unused;
  logic [15:0] rd_data, acc_addr, mem_addr, mem_wdata, status;
  logic [1:0]  mem_tgt;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vid_wr_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .cmd_load(cmd_load),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .autoinc(autoinc),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .slot_strobe(slot_strobe), .rd_req(rd_req), .rd_raw(rd_raw),
    .rd_valid(rd_valid), .rd_data(rd_data), .acc_addr(acc_addr),
    .mem_we(mem_we), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_byte(mem_byte), .slot_unused(slot_unused),
    .status(status)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reset_dut(input logic wide);
    @(negedge clk);
    rst_n = 1'b0; mode_wide = wide; cmd_load = 0; cmd_code = 0; cmd_addr = 0;
    autoinc = 8'd2; wr_valid = 0; wr_data = 0; slot_strobe = 0; rd_req = 0; rd_raw = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_cmd(input logic [3:0] code, input logic [15:0] addr);
    @(negedge clk);
    cmd_load = 1; cmd_code = code; cmd_addr = addr;
    @(posedge clk); #1 cmd_load = 0;
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1; wr_data = d;
    @(posedge clk); #1 wr_valid = 0;
  endtask

  task automatic do_slot();
    @(negedge clk);
    slot_strobe = 1;
    @(posedge clk); #1 slot_strobe = 0;
  endtask

  task automatic do_read(input logic [15:0] raw);
    @(negedge clk);
    rd_req = 1; rd_raw = raw;
    @(posedge clk); #1 rd_req = 0;
  endtask

  task automatic t_reset();
    reset_dut(1);
    chk("R1 status", status, 16'h3600);
    chk("R1 ready", {15'b0, wr_ready}, 16'h1);
    chk("R1 addr", acc_addr, 16'h0000);
    set_cmd(4'h8, 16'h0000);
    do_read(16'hFFFF);
    chk("R1 zero stale", rd_data, 16'h0EEE);
  endtask

  task automatic t_wide_latency();
    reset_dut(1);
    set_cmd(4'h3, 16'h0010);
    push(16'h0ABC);
    chk("R3 addr step", acc_addr, 16'h0012);
    chk("R2 not empty", status, 16'h3400);
    wait_cyc(40);
    do_slot();
    chk("R4 early unused", {15'b0, slot_unused}, 16'h1);
    chk("R4 early no write", {15'b0, mem_we}, 16'h0);
    wait_cyc(10);
    do_slot();
    chk("R5 cram we", {15'b0, mem_we}, 16'h1);
    chk("R5 cram tgt", {14'b0, mem_tgt}, 16'h1);
    chk("R5 cram addr", mem_addr, 16'h0010);
    chk("R5 cram data", mem_wdata, 16'h0ABC);
    chk("R5 empty after", status, 16'h3600);
  endtask

  task automatic t_narrow_latency();
    reset_dut(0);
    set_cmd(4'h5, 16'h0004);
    push(16'h0321);
    wait_cyc(50);
    do_slot();
    chk("R4 narrow unused", {15'b0, slot_unused}, 16'h1);
    wait_cyc(10);
    do_slot();
    chk("R4 narrow served", {15'b0, mem_we}, 16'h1);
    chk("R5 vsram tgt", {14'b0, mem_tgt}, 16'h2);
    chk("R5 vsram data", mem_wdata, 16'h0321);
  endtask

  task automatic t_vram_split();
    reset_dut(1);
    set_cmd(4'h1, 16'h0100);
    push(16'hABCD);
    wait_cyc(60);
    do_slot();
    chk("R6 hi we", {15'b0, mem_we}, 16'h1);
    chk("R6 hi byte", {15'b0, mem_byte}, 16'h1);
    chk("R6 hi addr", mem_addr, 16'h0100);
    chk("R6 hi data", mem_wdata, 16'h00AB);
    chk("R6 still queued", status, 16'h3400);
    do_slot();
    chk("R6 lo addr", mem_addr, 16'h0101);
    chk("R6 lo data", mem_wdata, 16'h00CD);
    chk("R6 popped", status, 16'h3600);
  endtask

  task automatic t_read_slot();
    reset_dut(1);
    set_cmd(4'h3, 16'h0000);
    push(16'h0123);
    wait_cyc(60);
    do_read(16'h0000);
    do_slot();
    chk("R7 read takes slot", {15'b0, slot_unused}, 16'h1);
    chk("R7 no write", {15'b0, mem_we}, 16'h0);
    chk("R7 kept", status, 16'h3400);
    do_slot();
    chk("R7 then served", mem_wdata, 16'h0123);
  endtask

  task automatic t_other_code();
    reset_dut(1);
    set_cmd(4'h0, 16'h0000);
    push(16'h7777);
    wait_cyc(60);
    do_slot();
    chk("R8 no write", {15'b0, mem_we}, 16'h0);
    chk("R8 not unused", {15'b0, slot_unused}, 16'h0);
    chk("R8 popped", status, 16'h3600);
  endtask

  task automatic t_full_order();
    reset_dut(1);
    set_cmd(4'h3, 16'h0000);
    push(16'h1111); push(16'h2222); push(16'h3333); push(16'h4444);
    chk("R2 full status", status, 16'h3500);
    chk("R2 ready low", {15'b0, wr_ready}, 16'h0);
    wait_cyc(60);
    @(negedge clk);
    wr_valid = 1; wr_data = 16'h5555; slot_strobe = 1;
    @(posedge clk); #1 slot_strobe = 0;
    chk("R12 first out", mem_wdata, 16'h1111);
    chk("R2 room again", {15'b0, wr_ready}, 16'h1);
    @(posedge clk); #1 wr_valid = 0;
    chk("R12 held accepted", status, 16'h3500);
    do_slot(); chk("R12 second", mem_wdata, 16'h2222);
    chk("R3 entry addr", mem_addr, 16'h0002);
    do_slot(); chk("R12 third", mem_wdata, 16'h3333);
    do_slot(); chk("R12 fourth", mem_wdata, 16'h4444);
    wait_cyc(60);
    do_slot(); chk("R12 held last", mem_wdata, 16'h5555);
    chk("R12 empty", status, 16'h3600);
  endtask

  task automatic t_same_cycle();
    reset_dut(1);
    set_cmd(4'h3, 16'h0040);
    push(16'h0AAA);
    wait_cyc(60);
    @(negedge clk);
    wr_valid = 1; wr_data = 16'h0BBB; slot_strobe = 1;
    @(posedge clk); #1 wr_valid = 0; slot_strobe = 0;
    chk("R11 old written", mem_wdata, 16'h0AAA);
    chk("R11 new kept", status, 16'h3400);
    wait_cyc(60);
    do_slot();
    chk("R11 new written", mem_wdata, 16'h0BBB);
    chk("R11 new addr", mem_addr, 16'h0042);
    chk("R11 empty", status, 16'h3600);
  endtask

  task automatic t_merge();
    reset_dut(1);
    set_cmd(4'h5, 16'h0000);
    push(16'h1234); push(16'h5678); push(16'h9ABC); push(16'hDEF0);
    wait_cyc(60);
    repeat (4) do_slot();
    chk("R9 drained", status, 16'h3600);
    set_cmd(4'h8, 16'h0020);
    do_read(16'hFFFF);
    chk("R9 cram valid", {15'b0, rd_valid}, 16'h1);
    chk("R9 cram merge", rd_data, 16'h1EFE);
    chk("R3 read step", acc_addr, 16'h0022);
    set_cmd(4'h4, 16'h0000);
    do_read(16'hFFFF);
    chk("R10 vsram merge", rd_data, 16'h13FF);
    set_cmd(4'h0, 16'h0000);
    do_read(16'hBEEF);
    chk("R10 raw read", rd_data, 16'hBEEF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_wide_latency();
    t_narrow_latency();
    t_vram_split();
    t_read_slot();
    t_other_code();
    t_full_order();
    t_same_cycle();
    t_merge();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule